// File: doc/BRIEF.md
# Packet header parser and route filter

This block sits on the receive byte stream of one router port. It reads a four-byte header as the bytes arrive: source byte, destination byte, then a two-byte payload length sent high byte first. When the last header byte comes in, it publishes the header fields together with a forwarding mask that has one bit per output port. Two table lookups build the mask. A routing table is indexed by destination, and a permission table is indexed by source. The mask is the bitwise AND of the two entries.

After the header, the parser skips exactly the announced number of payload bytes and then expects the next header. It does not store or move the payload. A packet is dropped when its length is outside the legal range or when its final mask is empty.

Both tables are register arrays. They clear on reset and are loaded through a synchronous write port. The port count is a parameter, so the mask grows with the router.

Top module: `hrf_route_filter`

## Requirements
- R1: Header bytes accepted on `rx_valid_i` are taken in this order: source, destination, length high byte, length low byte. The source and destination appear on `hdr_src_o` and `hdr_dst_o`.
- R2: `hdr_len_o` equals 256 × (third header byte) + (fourth header byte).
- R3: `hdr_valid_o` is high for exactly one cycle, on the cycle after the clock edge that accepts the fourth header byte. It is low at all other times.
- R4: For a legal length, `port_mask_o` equals route[destination] AND permit[source]. Bit p of the mask stands for output port p. Several bits may be set (broadcast), and any bit may be set, including the port feeding this parser (loopback).
- R5: A length below LEN_MIN (4) or above LEN_MAX (2000) raises `drop_o` and forces `port_mask_o` to zero.
- R6: A legal length whose mask comes out all zero also raises `drop_o`. `drop_o` is only ever high together with `hdr_valid_o`.
- R7: After the header, exactly `hdr_len_o` further accepted bytes are treated as payload. This holds for dropped packets too. The next accepted byte starts a new header, and a length of 0 means the very next byte is a new header.
- R8: Bytes presented while `rx_valid_i` is low are ignored.
- R9: After reset, both tables hold all zeros and all outputs are zero.
- R10: A write with `tbl_we_i` high loads `tbl_data_i` into entry `tbl_addr_i`. A `tbl_sel_i` of 0 selects the routing table (indexed by destination) and 1 selects the permission table (indexed by source). The write affects headers whose fourth byte is accepted on a later edge.
- R11: Between `hdr_valid_o` pulses, the header fields and `port_mask_o` hold their last values.
- R12: The mask width follows NUM_PORTS, and port bits at index 4 and above work like the lower ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tbl_we_i | input | 1 | Table write enable |
| tbl_sel_i | input | 1 | 0 selects the routing table, 1 selects the permission table |
| tbl_addr_i | input | 8 | Table entry index |
| tbl_data_i | input | NUM_PORTS | Port set written to the entry |
| hdr_valid_o | output | 1 | One-cycle strobe for a decoded header |
| hdr_src_o | output | 8 | Source field |
| hdr_dst_o | output | 8 | Destination field |
| hdr_len_o | output | 16 | Payload length field |
| port_mask_o | output | NUM_PORTS | Forwarding mask |
| drop_o | output | 1 | Packet is to be discarded |

## Verification
Every result is registered on the clock edge that accepts the fourth header byte. The fields, mask, drop flag and valid strobe can therefore all be read in the cycle after that edge, and the strobe is gone one edge later. A table write becomes visible from the edge after the one that performs it. The bench drives each byte or write at a falling edge and reads the outputs at the next falling edge. It checks that the strobe is absent after the third byte, present after the fourth, and absent again one cycle on. It counts strobes across each payload to confirm that the skip length is exact.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LEN_W  = 16;

  typedef enum logic [2:0] {
    ST_SRC,
    ST_DST,
    ST_LEN_HI,
    ST_LEN_LO,
    ST_BODY
  } parse_st_e;
endpackage

// File: rtl/hrf_port_table.sv
module hrf_port_table #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned IDX_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     waddr_i,
  input  logic [NUM_PORTS-1:0] wdata_i,
  input  logic [IDX_W-1:0]     raddr_i,
  output logic [NUM_PORTS-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [NUM_PORTS-1:0] entry_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) entry_q[e] <= '0;
    end else if (we_i) begin
      entry_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = entry_q[raddr_i];
endmodule

// File: rtl/hrf_byte_parser.sv
module hrf_byte_parser
  import hrf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [BYTE_W-1:0] src_o,
  output logic [BYTE_W-1:0] dst_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              hdr_done_o
);
  parse_st_e          st_q, st_d;
  logic [BYTE_W-1:0]  src_q, dst_q, len_hi_q;
  logic [LEN_W-1:0]   body_cnt_q;
  logic [LEN_W-1:0]   len_full;

  assign len_full   = {len_hi_q, rx_byte_i};
  assign hdr_done_o = rx_valid_i && (st_q == ST_LEN_LO);

  always_comb begin
    st_d = st_q;
    if (rx_valid_i) begin
      unique case (st_q)
        ST_SRC:    st_d = ST_DST;
        ST_DST:    st_d = ST_LEN_HI;
        ST_LEN_HI: st_d = ST_LEN_LO;
        ST_LEN_LO: st_d = (len_full == '0) ? ST_SRC : ST_BODY;
        ST_BODY:   st_d = (body_cnt_q == LEN_W'(1)) ? ST_SRC : ST_BODY;
        default:   st_d = ST_SRC;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_SRC;
      src_q      <= '0;
      dst_q      <= '0;
      len_hi_q   <= '0;
      body_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (rx_valid_i) begin
        unique case (st_q)
          ST_SRC:    src_q      <= rx_byte_i;
          ST_DST:    dst_q      <= rx_byte_i;
          ST_LEN_HI: len_hi_q   <= rx_byte_i;
          ST_LEN_LO: body_cnt_q <= len_full;
          ST_BODY:   body_cnt_q <= body_cnt_q - LEN_W'(1);
          default:   ;
        endcase
      end
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign len_o = len_full;
endmodule

// File: rtl/hrf_verdict.sv
module hrf_verdict #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned LEN_MIN   = 4,
  parameter int unsigned LEN_MAX   = 2000
) (
  input  logic [LEN_W-1:0]     len_i,
  input  logic [NUM_PORTS-1:0] route_i,
  input  logic [NUM_PORTS-1:0] permit_i,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 drop_o
);
  logic                 len_ok;
  logic [NUM_PORTS-1:0] allowed;

  assign len_ok = (len_i >= LEN_W'(LEN_MIN)) && (len_i <= LEN_W'(LEN_MAX));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign allowed[p] = route_i[p] & permit_i[p] & len_ok;
  end

  assign mask_o = allowed;
  assign drop_o = ~|allowed;
endmodule

// File: rtl/hrf_route_filter.sv
module hrf_route_filter
  import hrf_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LEN_MIN   = 4,
  parameter int unsigned LEN_MAX   = 2000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_byte_i,
  input  logic                 tbl_we_i,
  input  logic                 tbl_sel_i,
  input  logic [7:0]           tbl_addr_i,
  input  logic [NUM_PORTS-1:0] tbl_data_i,
  output logic                 hdr_valid_o,
  output logic [7:0]           hdr_src_o,
  output logic [7:0]           hdr_dst_o,
  output logic [15:0]          hdr_len_o,
  output logic [NUM_PORTS-1:0] port_mask_o,
  output logic                 drop_o
);
  logic [BYTE_W-1:0]    cur_src, cur_dst;
  logic [LEN_W-1:0]     cur_len;
  logic                 hdr_done;
  logic [NUM_PORTS-1:0] route_rd, permit_rd, fwd_mask;
  logic                 fwd_drop;

  hrf_byte_parser u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .src_o      (cur_src),
    .dst_o      (cur_dst),
    .len_o      (cur_len),
    .hdr_done_o (hdr_done)
  );

  hrf_port_table #(.NUM_PORTS(NUM_PORTS), .IDX_W(BYTE_W)) u_route_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i & ~tbl_sel_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (cur_dst),
    .rdata_o (route_rd)
  );

  hrf_port_table #(.NUM_PORTS(NUM_PORTS), .IDX_W(BYTE_W)) u_permit_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i & tbl_sel_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (cur_src),
    .rdata_o (permit_rd)
  );

  hrf_verdict #(
    .NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)
  ) u_verdict (
    .len_i    (cur_len),
    .route_i  (route_rd),
    .permit_i (permit_rd),
    .mask_o   (fwd_mask),
    .drop_o   (fwd_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_valid_o <= 1'b0;
      drop_o      <= 1'b0;
      hdr_src_o   <= '0;
      hdr_dst_o   <= '0;
      hdr_len_o   <= '0;
      port_mask_o <= '0;
    end else begin
      hdr_valid_o <= hdr_done;
      drop_o      <= hdr_done & fwd_drop;
      if (hdr_done) begin
        hdr_src_o   <= cur_src;
        hdr_dst_o   <= cur_dst;
        hdr_len_o   <= cur_len;
        port_mask_o <= fwd_mask;
      end
    end
  end
endmodule

// File: rtl/hrf_route_filter_chk.sv
module hrf_route_filter_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned LEN_MIN   = 4,
  parameter int unsigned LEN_MAX   = 2000
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_valid_i,
  input logic                 hdr_valid_o,
  input logic [7:0]           hdr_src_o,
  input logic [7:0]           hdr_dst_o,
  input logic [15:0]          hdr_len_o,
  input logic [NUM_PORTS-1:0] port_mask_o,
  input logic                 drop_o
);
  // R3
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o);

  // R3
  valid_after_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> $past(rx_valid_i));

  // R5
  legal_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && !drop_o) |-> (hdr_len_o >= 16'(LEN_MIN) && hdr_len_o <= 16'(LEN_MAX)));

  // R6
  drop_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (drop_o == (port_mask_o == '0)));

  // R6
  drop_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> hdr_valid_o);

  // R11
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_o |-> ($stable(hdr_src_o) && $stable(hdr_dst_o)
                      && $stable(hdr_len_o) && $stable(port_mask_o)));
endmodule

bind hrf_route_filter hrf_route_filter_chk #(
  .NUM_PORTS(NUM_PORTS), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .hdr_valid_o (hdr_valid_o),
  .hdr_src_o   (hdr_src_o),
  .hdr_dst_o   (hdr_dst_o),
  .hdr_len_o   (hdr_len_o),
  .port_mask_o (port_mask_o),
  .drop_o      (drop_o)
);

// File: tb/hrf_route_filter_test.sv
module hrf_route_filter_test;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          tbl_we = 1'b0;
  logic          tbl_sel = 1'b0;
  logic [7:0]    tbl_addr = '0;
  logic [NP-1:0] tbl_data = '0;
  logic          hdr_valid;
  logic [7:0]    hdr_src, hdr_dst;
  logic [15:0]   hdr_len;
  logic [NP-1:0] port_mask;
  logic          drop;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;
  logic [NP-1:0] route_m [256];
  logic [NP-1:0] perm_m  [256];

  always #4 clk = ~clk;

  hrf_route_filter #(.NUM_PORTS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .hdr_valid_o(hdr_valid), .hdr_src_o(hdr_src), .hdr_dst_o(hdr_dst),
    .hdr_len_o(hdr_len), .port_mask_o(port_mask), .drop_o(drop)
  );

  always @(negedge clk) if (rst_n && hdr_valid) pulse_cnt++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h5A;
  endtask

  task automatic tbl_write(input bit sel, input logic [7:0] a, input logic [NP-1:0] d);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = a; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
    if (sel) perm_m[a] = d; else route_m[a] = d;
  endtask

  // header, checks, then payload of nskip bytes (header-like filler)
  task automatic send_pkt(input logic [7:0] s, input logic [7:0] d, input logic [15:0] len,
                          input int nskip, input string tag);
    logic [NP-1:0] exp_m;
    bit legal;
    int p0;
    legal = (len >= 4) && (len <= 2000);
    exp_m = legal ? (route_m[d] & perm_m[s]) : '0;
    p0 = pulse_cnt;
    send_byte(s); send_byte(d); send_byte(len[15:8]);
    chk(hdr_valid == 1'b0, {"R3 early ", tag}, hdr_valid, 0);
    send_byte(len[7:0]);
    chk(hdr_valid == 1'b1, {"R3 strobe ", tag}, hdr_valid, 1);
    chk(hdr_src == s && hdr_dst == d, {"R1 fields ", tag}, {hdr_src, hdr_dst}, {s, d});
    chk(hdr_len == len, {"R2 length ", tag}, hdr_len, len);
    chk(port_mask == exp_m, {"R4 mask ", tag}, port_mask, exp_m);
    chk(drop == (exp_m == '0), {"R5 R6 drop ", tag}, drop, exp_m == '0);
    @(negedge clk);
    chk(hdr_valid == 1'b0 && drop == 1'b0, {"R3 one cycle ", tag}, hdr_valid, 0);
    chk(hdr_len == len && port_mask == exp_m, {"R11 hold ", tag}, port_mask, exp_m);
    for (int i = 0; i < nskip; i++) send_byte(8'(i * 7 + 3));
    chk(pulse_cnt == p0 + 1, {"R7 one header per packet ", tag}, pulse_cnt - p0, 1);
  endtask

  task automatic t_reset;
    chk(hdr_valid == 0 && port_mask == '0 && drop == 0 && hdr_len == '0,
        "R9 reset outputs", {hdr_valid, port_mask, drop}, 0);
    send_pkt(8'h01, 8'h02, 16'd4, 4, "R9 empty tables");
  endtask

  task automatic t_unicast;
    tbl_write(1'b0, 8'h21, 6'b000100);
    tbl_write(1'b1, 8'h10, 6'b111111);
    send_pkt(8'h10, 8'h21, 16'h0010, 16, "R10 unicast");
    send_pkt(8'h10, 8'h21, 16'h0105, 16'h0105, "R2 high byte");
  endtask

  task automatic t_broadcast;
    tbl_write(1'b0, 8'h30, 6'b110101);
    tbl_write(1'b1, 8'h11, 6'b100011);
    send_pkt(8'h11, 8'h30, 16'd9, 9, "R12 broadcast with loopback bit0 and bit5");
    tbl_write(1'b1, 8'h11, 6'b010010);
    send_pkt(8'h11, 8'h30, 16'd5, 5, "R12 bit4 after rewrite");
  endtask

  task automatic t_mask_zero;
    tbl_write(1'b1, 8'h12, 6'b001010);
    send_pkt(8'h12, 8'h30, 16'd6, 6, "R6 filtered empty");
  endtask

  task automatic t_len_bounds;
    send_pkt(8'h10, 8'h21, 16'd3, 3, "R5 len3");
    send_pkt(8'h10, 8'h21, 16'd4, 4, "R5 len4");
    send_pkt(8'h10, 8'h21, 16'd2000, 2000, "R5 len2000");
    send_pkt(8'h10, 8'h21, 16'd2001, 2001, "R5 len2001");
    send_pkt(8'h10, 8'h21, 16'd0, 0, "R7 len0");
    send_pkt(8'h10, 8'h21, 16'd7, 7, "R7 after len0");
  endtask

  task automatic t_stall;
    int p0;
    p0 = pulse_cnt;
    send_byte(8'h10);
    for (int i = 0; i < 3; i++) begin rx_byte = 8'hC3; @(negedge clk); end
    send_byte(8'h21);
    send_byte(8'h00);
    for (int i = 0; i < 5; i++) begin rx_byte = 8'h04; @(negedge clk); end
    chk(hdr_valid == 0 && pulse_cnt == p0, "R8 idle bytes ignored", pulse_cnt - p0, 0);
    send_byte(8'h04);
    chk(hdr_valid == 1 && hdr_len == 16'd4 && port_mask == 6'b000100,
        "R8 header across stalls", {hdr_len, port_mask}, {16'd4, 6'b000100});
    @(negedge clk);
    for (int i = 0; i < 4; i++) send_byte(8'hEE);
    send_pkt(8'h10, 8'h21, 16'd4, 4, "R8 next after stalled");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin route_m[i] = '0; perm_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_mask_zero();
    t_len_bounds();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule